// File: doc/BRIEF.md
# Flash Shadow-Row Program/Erase Sequencer

This block orders program and erase work on a small flash model. The model has three main regions (low, mid, high) and one separate shadow row. Each region holds `SEGS` segments of 64 bits. A space-select input decides where program and erase commands go. When it is 1, they go to the shadow row. When it is 0, they go to the main region named in the address. The block checks a lock bit for each region. It allows exactly one program per segment between erases. It lets an erase be suspended for a program in the same address space, and it lets any running operation be aborted.

Cell timing is modelled with down-counters loaded from parameters. The array contents change only when an operation completes. A read port returns the addressed segment one cycle after the request. While a high-voltage operation makes a region unreadable, the read port answers with an access error instead, as set out in R11. Status outputs report busy, completion, command rejection and a suspended erase.

Top module: `flash_shadow_seq`

## Requirements
- R1: After reset, busy, done, err and suspended are 0, every segment reads as all ones, and no segment is marked as programmed.
- R2: Address bits [AW-1:SW] select the region (0 low, 1 mid, 2 high, 3 shadow) and bits [SW-1:0] select the segment. For program and erase, space_sel=1 targets the shadow row whatever the region field holds. With space_sel=0, a region field of 3 is rejected with err.
- R3: cmd_op encodings are 1 program, 2 erase, 3 suspend, 4 resume and 5 abort. An accepted program keeps busy high for PROG_CYC cycles and an erase for ERS_CYC cycles. The array is updated when busy falls, and done is high for exactly that one following cycle.
- R4: A program to a segment already programmed since its region's last erase sets err and leaves the data unchanged.
- R5: A program or erase whose target region has its lock bit set (lock bit index equals region code) sets err and changes nothing.
- R6: A completed erase sets every segment of the target region to all ones and clears their programmed marks.
- R7: Suspend is accepted only while an erase is running. The erase stops counting, busy drops and suspended rises. A suspend at any other time sets err.
- R8: While an erase is suspended, a program is accepted only if it targets the same address space (shadow versus main) and a region other than the one being erased. Otherwise it sets err.
- R9: Resume continues a suspended erase with its remaining count, so total erase busy time stays ERS_CYC. A resume with nothing suspended, or while a program is running, sets err.
- R10: Abort ends any running or suspended operation at once, without done and without changing the array or the programmed marks.
- R11: While a shadow operation runs, every read is refused. While a main-region operation runs, reads of that region and of the shadow row are refused. While an erase is suspended, reads of its region are refused. A refused read returns rd_err=1 with all-ones data.
- R12: A read returns rd_valid one cycle after rd_en, carrying the addressed segment with rd_err=0 when it is not refused.
- R13: A program or erase issued while busy is high sets err and is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd_valid | input | 1 | Command strobe |
| cmd_op | input | 3 | Command code |
| cmd_addr | input | AW | Command region and segment |
| cmd_data | input | 64 | Program data |
| space_sel | input | 1 | 1 steers program/erase to the shadow row |
| lock | input | 4 | Lock bit for each region |
| rd_en | input | 1 | Read request |
| rd_addr | input | AW | Read region and segment |
| rd_valid | output | 1 | Read response strobe |
| rd_data | output | 64 | Read data, all ones when refused |
| rd_err | output | 1 | Read refused |
| busy | output | 1 | An operation is counting |
| done | output | 1 | Operation completed (one cycle) |
| err | output | 1 | Previous command rejected |
| suspended | output | 1 | An erase is suspended |

## Verification
The embedded assertions check these rules on every cycle:
- a locked program target and a repeated program each raise err;
- a program or erase issued while busy raises err;
- done never lasts two cycles;
- a suspended erase's counter does not move;
- any read issued during a shadow operation comes back refused with all-ones data.

Other behaviour needs the bench's scenarios:
- the space steering and region decode;
- the contents left by program, erase and abort;
- busy durations that add up across a suspend with a nested program;
- which reads stay allowed during main-region work and during a suspension.

// File: rtl/flash_shadow_seq.sv
module flash_shadow_seq #(
  parameter int SEGS     = 4,
  parameter int DW       = 64,
  parameter int PROG_CYC = 4,
  parameter int ERS_CYC  = 12
) (
  input  logic                                clk,
  input  logic                                rst_n,
  input  logic                                cmd_valid,
  input  logic [2:0]                          cmd_op,
  input  logic [$clog2(SEGS)+1:0]             cmd_addr,
  input  logic [DW-1:0]                       cmd_data,
  input  logic                                space_sel,
  input  logic [3:0]                          lock,
  input  logic                                rd_en,
  input  logic [$clog2(SEGS)+1:0]             rd_addr,
  output logic                                rd_valid,
  output logic [DW-1:0]                       rd_data,
  output logic                                rd_err,
  output logic                                busy,
  output logic                                done,
  output logic                                err,
  output logic                                suspended
);
  localparam int SW   = $clog2(SEGS);
  localparam int AW   = SW + 2;
  localparam int NW   = 1 << AW;
  localparam int MAXC = (PROG_CYC > ERS_CYC) ? PROG_CYC : ERS_CYC;
  localparam int CW   = $clog2(MAXC + 1);
  localparam logic [1:0] SHD = 2'd3;
  localparam logic [2:0] OP_PROG = 3'd1, OP_ERS = 3'd2, OP_SUS = 3'd3,
                         OP_RES = 3'd4, OP_ABT = 3'd5;

  logic [DW-1:0] mem [NW];
  logic [NW-1:0] pflag;

  logic          prg_act;
  logic [AW-1:0] prg_idx;
  logic [DW-1:0] prg_dat;
  logic [CW-1:0] prg_cnt;
  logic          ers_act, ers_susp;
  logic [1:0]    ers_rgn;
  logic [CW-1:0] ers_cnt;

  wire [1:0]    c_field = cmd_addr[AW-1:SW];
  wire [1:0]    c_rgn   = space_sel ? SHD : c_field;
  wire          c_bad   = !space_sel && (c_field == SHD);
  wire [AW-1:0] c_idx   = {c_rgn, cmd_addr[SW-1:0]};

  wire is_prog = cmd_valid && cmd_op == OP_PROG;
  wire is_ers  = cmd_valid && cmd_op == OP_ERS;
  wire is_sus  = cmd_valid && cmd_op == OP_SUS;
  wire is_res  = cmd_valid && cmd_op == OP_RES;
  wire is_abt  = cmd_valid && cmd_op == OP_ABT;

  wire ers_run    = ers_act && !ers_susp;
  wire same_space = (c_rgn == SHD) == (ers_rgn == SHD);

  assign busy      = ers_run || prg_act;
  assign suspended = ers_susp;

  wire prog_ok = is_prog && !c_bad && !lock[c_rgn] && !pflag[c_idx] && !busy &&
                 (!ers_act || (same_space && c_rgn != ers_rgn));
  wire ers_ok  = is_ers && !c_bad && !lock[c_rgn] && !busy && !ers_act;
  wire sus_ok  = is_sus && ers_run;
  wire res_ok  = is_res && ers_susp && !prg_act;
  wire cmd_err = (is_prog && !prog_ok) || (is_ers && !ers_ok) ||
                 (is_sus && !sus_ok) || (is_res && !res_ok);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NW; i++) mem[i] <= '1;
      pflag    <= '0;
      prg_act  <= 1'b0;
      prg_idx  <= '0;
      prg_dat  <= '0;
      prg_cnt  <= '0;
      ers_act  <= 1'b0;
      ers_susp <= 1'b0;
      ers_rgn  <= '0;
      ers_cnt  <= '0;
      done     <= 1'b0;
      err      <= 1'b0;
    end else begin
      done <= 1'b0;
      err  <= cmd_err;
      if (is_abt) begin
        prg_act  <= 1'b0;
        ers_act  <= 1'b0;
        ers_susp <= 1'b0;
      end else begin
        if (prg_act) begin
          if (prg_cnt == CW'(1)) begin
            prg_act        <= 1'b0;
            done           <= 1'b1;
            mem[prg_idx]   <= prg_dat;
            pflag[prg_idx] <= 1'b1;
          end else prg_cnt <= prg_cnt - 1'b1;
        end else if (prog_ok) begin
          prg_act <= 1'b1;
          prg_cnt <= CW'(PROG_CYC);
          prg_idx <= c_idx;
          prg_dat <= cmd_data;
        end
        if (ers_run) begin
          if (ers_cnt != CW'(1)) ers_cnt <= ers_cnt - 1'b1;
          else if (!sus_ok) begin
            ers_act <= 1'b0;
            done    <= 1'b1;
            for (int s = 0; s < SEGS; s++) begin
              mem[AW'((int'(ers_rgn) << SW) + s)]   <= '1;
              pflag[AW'((int'(ers_rgn) << SW) + s)] <= 1'b0;
            end
          end
        end else if (ers_ok) begin
          ers_act <= 1'b1;
          ers_rgn <= c_rgn;
          ers_cnt <= CW'(ERS_CYC);
        end
        if (sus_ok) ers_susp <= 1'b1;
        if (res_ok) ers_susp <= 1'b0;
      end
    end
  end

  wire [1:0] r_rgn   = rd_addr[AW-1:SW];
  wire [1:0] p_rgn   = prg_idx[AW-1:SW];
  wire shadow_busy   = (prg_act && p_rgn == SHD) || (ers_run && ers_rgn == SHD);
  wire main_hit      = (prg_act && p_rgn != SHD && (r_rgn == p_rgn || r_rgn == SHD)) ||
                       (ers_run && ers_rgn != SHD && (r_rgn == ers_rgn || r_rgn == SHD));
  wire susp_hit      = ers_susp && r_rgn == ers_rgn;
  wire rd_block      = shadow_busy || main_hit || susp_hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_err   <= 1'b0;
      rd_data  <= '1;
    end else begin
      rd_valid <= rd_en;
      rd_err   <= rd_en && rd_block;
      rd_data  <= (rd_en && !rd_block) ? mem[rd_addr] : '1;
    end
  end

  // R5
  lock_reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (is_prog || is_ers) && !c_bad && lock[c_rgn] |=> err);

  // R4
  reprog_reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
    is_prog && pflag[c_idx] |=> err);

  // R13
  busy_reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy && (is_prog || is_ers) |=> err);

  // R3
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R7
  susp_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ers_susp |=> $stable(ers_cnt));

  // R11
  shadow_read_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en && shadow_busy |=> rd_valid && rd_err && (&rd_data));
endmodule

// File: tb/flash_shadow_seq_test.sv
module flash_shadow_seq_test;
  localparam int PERIOD = 10;
  localparam int PC = 4;
  localparam int EC = 12;
  localparam logic [2:0] P = 3'd1, E = 3'd2, SUS = 3'd3, RES = 3'd4, ABT = 3'd5;
  localparam logic [63:0] ONES = '1;

  logic clk = 0, rst_n = 0;
  logic cmd_valid = 0, space_sel = 0, rd_en = 0;
  logic [2:0] cmd_op = 0;
  logic [3:0] cmd_addr = 0, rd_addr = 0, lock = 0;
  logic [63:0] cmd_data = 0;
  logic rd_valid, rd_err, busy, done, err, suspended;
  logic [63:0] rd_data;

  always #(PERIOD/2) clk = ~clk;

  flash_shadow_seq #(.SEGS(4), .DW(64), .PROG_CYC(PC), .ERS_CYC(EC)) uut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_addr(cmd_addr), .cmd_data(cmd_data), .space_sel(space_sel), .lock(lock),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_valid(rd_valid), .rd_data(rd_data),
    .rd_err(rd_err), .busy(busy), .done(done), .err(err), .suspended(suspended));

  typedef struct packed {
    logic [2:0]  op;
    logic        sel;
    logic [3:0]  addr;
    logic [3:0]  lk;
    logic [63:0] dat;
    logic        xerr;
  } vec_t;

  localparam vec_t VT [13] = '{
    '{P, 1'b0, 4'h1, 4'h0, 64'h0123_4567_89AB_CDEF, 1'b0},
    '{P, 1'b0, 4'h1, 4'h0, 64'hFFFF_0000_FFFF_0000, 1'b1},
    '{P, 1'b1, 4'h1, 4'h0, 64'hDEAD_BEEF_0000_1111, 1'b0},
    '{P, 1'b0, 4'hC, 4'h0, 64'h0000_0000_0000_00AA, 1'b1},
    '{P, 1'b0, 4'hB, 4'h4, 64'h5555_AAAA_5555_AAAA, 1'b1},
    '{P, 1'b0, 4'hB, 4'h0, 64'h5555_AAAA_5555_AAAA, 1'b0},
    '{P, 1'b1, 4'hA, 4'h8, 64'h0000_0000_0000_0001, 1'b1},
    '{E, 1'b0, 4'h1, 4'h0, 64'h0,                   1'b0},
    '{P, 1'b0, 4'h1, 4'h0, 64'h0F0F_0F0F_0F0F_0F0F, 1'b0},
    '{E, 1'b1, 4'h0, 4'h8, 64'h0,                   1'b1},
    '{E, 1'b1, 4'h2, 4'h0, 64'h0,                   1'b0},
    '{P, 1'b1, 4'h1, 4'h0, 64'h7777_8888_9999_AAAA, 1'b0},
    '{E, 1'b0, 4'hC, 4'h0, 64'h0,                   1'b1}
  };

  int nvec = 0, nbad = 0, busy_cnt = 0;
  logic [63:0] ref_mem [16];
  logic [63:0] rdat;
  logic rerr, rval;

  always @(negedge clk) if (busy) busy_cnt = busy_cnt + 1;

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    nvec++;
    if (act !== exp) begin
      nbad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic cmd(input logic [2:0] op, input logic sel, input logic [3:0] a,
                     input logic [63:0] d);
    cmd_valid = 1; cmd_op = op; space_sel = sel; cmd_addr = a; cmd_data = d;
    @(negedge clk);
    cmd_valid = 0; cmd_op = 0;
  endtask

  task automatic rd(input logic [3:0] a);
    rd_en = 1; rd_addr = a;
    @(negedge clk);
    rd_en = 0;
    rdat = rd_data; rerr = rd_err; rval = rd_valid;
  endtask

  task automatic run_out(output int n, output logic dn);
    n = 0;
    while (busy && n < 1000) begin n++; @(negedge clk); end
    dn = done;
  endtask

  initial begin
    #(PERIOD * 150000);
    nbad++;
    $display("FAIL watchdog: actual running expected finished");
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end

  initial begin
    int n;
    logic dn;
    for (int i = 0; i < 16; i++) ref_mem[i] = ONES;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    check("R1 busy", 64'(busy), 64'd0);
    check("R1 suspended", 64'(suspended), 64'd0);
    check("R1 err/done", 64'({err, done}), 64'd0);
    rd(4'h4);
    check("R1 erased read", rdat, ONES);
    check("R12 valid/ok", 64'({rval, rerr}), 64'b10);

    for (int v = 0; v < 13; v++) begin
      logic [3:0] tgt;
      tgt = {VT[v].sel ? 2'd3 : VT[v].addr[3:2], VT[v].addr[1:0]};
      lock = VT[v].lk;
      cmd(VT[v].op, VT[v].sel, VT[v].addr, VT[v].dat);
      lock = 0;
      // R2 R4 R5 routing, single program, lock
      check($sformatf("R2/R4/R5 err vec %0d", v), 64'(err), 64'(VT[v].xerr));
      if (!VT[v].xerr) begin
        run_out(n, dn);
        // R3 duration and done
        check($sformatf("R3 busy cycles vec %0d", v), 64'(n), 64'(VT[v].op == P ? PC : EC));
        check($sformatf("R3 done vec %0d", v), 64'(dn), 64'd1);
        if (VT[v].op == P) ref_mem[tgt] = VT[v].dat;
        else for (int s = 0; s < 4; s++) ref_mem[{tgt[3:2], 2'(s)}] = ONES;
      end
      rd(tgt);
      // R6 R12 contents after command
      check($sformatf("R6/R12 data vec %0d", v), rdat, ref_mem[tgt]);
    end
    rd(4'hD);
    check("R6 shadow seg1 after erase+program", rdat, 64'h7777_8888_9999_AAAA);

    // R11 reads during a main program
    cmd(P, 0, 4'h2, 64'h1111_2222_3333_4444);
    rd(4'h7);
    check("R11 other main region allowed", {rdat[62:0], rerr}, {ref_mem[7][62:0], 1'b0});
    rd(4'hD);
    check("R11 shadow refused during main op", {rdat[62:0], rerr}, {ONES[62:0], 1'b1});
    rd(4'h1);
    check("R11 same region refused", {rdat[62:0], rerr}, {ONES[62:0], 1'b1});
    run_out(n, dn);
    rd(4'h2);
    check("R3 program committed", rdat, 64'h1111_2222_3333_4444);

    // R11 shadow op blocks all, R13 commands while busy
    cmd(P, 1, 4'h3, 64'hCAFE_0000_0000_CAFE);
    rd(4'h7);
    check("R11 main refused during shadow op", {rdat[62:0], rerr}, {ONES[62:0], 1'b1});
    cmd(P, 0, 4'h8, 64'h9);
    check("R13 program while busy", 64'(err), 64'd1);
    cmd(E, 0, 4'h8, 64'h0);
    check("R13 erase while busy", 64'(err), 64'd1);
    run_out(n, dn);
    rd(4'h8);
    check("R13 ignored program", rdat, ONES);
    rd(4'hF);
    check("R3 shadow program", rdat, 64'hCAFE_0000_0000_CAFE);

    // R7 R8 R9 suspend, nested program, resume
    busy_cnt = 0;
    cmd(E, 0, 4'h4, 64'h0);
    @(negedge clk); @(negedge clk);
    cmd(SUS, 0, 4'h0, 64'h0);
    check("R7 suspend accepted", 64'({err, suspended, busy}), 64'b010);
    cmd(SUS, 0, 4'h0, 64'h0);
    check("R7 suspend when not running", 64'(err), 64'd1);
    repeat (3) @(negedge clk);
    check("R7 stays suspended", 64'({suspended, busy}), 64'b10);
    rd(4'h8);
    check("R11 other region readable while suspended", {rdat[62:0], rerr}, {ONES[62:0], 1'b0});
    rd(4'h7);
    check("R11 erased region refused while suspended", 64'(rerr), 64'd1);
    cmd(P, 1, 4'h0, 64'h5);
    check("R8 other space rejected", 64'(err), 64'd1);
    cmd(P, 0, 4'h5, 64'h5);
    check("R8 erased region rejected", 64'(err), 64'd1);
    cmd(P, 0, 4'h8, 64'hABCD_ABCD_ABCD_ABCD);
    check("R8 same-space program accepted", 64'({err, busy}), 64'b01);
    cmd(RES, 0, 4'h0, 64'h0);
    check("R9 resume during program", 64'(err), 64'd1);
    run_out(n, dn);
    check("R8 nested program done", 64'({dn, suspended}), 64'b11);
    rd(4'h8);
    check("R8 nested program data", rdat, 64'hABCD_ABCD_ABCD_ABCD);
    cmd(RES, 0, 4'h0, 64'h0);
    check("R9 resume accepted", 64'({err, suspended, busy}), 64'b001);
    run_out(n, dn);
    check("R9 erase done", 64'(dn), 64'd1);
    @(negedge clk);
    check("R9 total busy cycles", 64'(busy_cnt), 64'(EC + PC));
    rd(4'h7);
    check("R6 mid region erased", rdat, ONES);

    // R10 abort program and suspended erase
    cmd(P, 1, 4'h2, 64'h4242_4242_4242_4242);
    @(negedge clk);
    cmd(ABT, 0, 4'h0, 64'h0);
    check("R10 abort stops program", 64'({busy, done, err}), 64'b000);
    rd(4'hE);
    check("R10 aborted program left data", rdat, ONES);
    cmd(P, 1, 4'h2, 64'h4242_4242_4242_4242);
    check("R10 segment still unprogrammed", 64'(err), 64'd0);
    run_out(n, dn);
    rd(4'hE);
    check("R10 reprogram data", rdat, 64'h4242_4242_4242_4242);
    cmd(E, 0, 4'h8, 64'h0);
    cmd(SUS, 0, 4'h0, 64'h0);
    cmd(ABT, 0, 4'h0, 64'h0);
    check("R10 abort clears suspend", 64'({suspended, busy, done}), 64'b000);
    rd(4'h8);
    check("R10 aborted erase kept data", rdat, 64'hABCD_ABCD_ABCD_ABCD);

    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end
endmodule